// File: doc/BRIEF.md
# Flash Erase and Program Control Registers

This block is a small set of special-function registers that sits on the 8-bit register bus of a microcontroller core. Firmware uses it to start a page erase or a whole-array erase of the on-chip flash, and to turn on byte programming. Three registers are provided. A command register starts an erase when a key value is written to it. A page register holds the target page. A control register holds the program-write enable, the whole-array erase enable and a security bit.

Before an erase request reaches the flash array, each erase must be armed again. A page erase needs a fresh write to the page register. A whole-array erase needs a prior write of its enable bit and an active debug port. A request is a single-cycle pulse, and for a page erase it comes with the page number. While the program-write enable is set, the next external-data write is steered to flash instead of external RAM, and the enable then drops by itself. The security bit can only be set; reset is the only way to clear it.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, all three registers read 0x00. No erase request is active, the program-write enable is low and the security output is low.
- R2: The page register is at address 0xB7 and holds the page number shifted left by one, so a page erase targets page = bits 7:1. After the page register is written, writing 0x55 to the command register (address 0x94) raises pageEraseReq for exactly one cycle, in the cycle after the write, with erasePage equal to that page.
- R3: A 0x55 command gives no request unless the page register was written after the previous 0x55 command. Every 0x55 write consumes the page arm.
- R4: The control register is at address 0xB2, and bit 1 is the whole-array erase enable. Writing 0xAA to the command register raises massEraseReq for one cycle, in the cycle after the write, only when that bit is 1 and debugEnable is high. Every 0xAA write clears the bit.
- R5: A command value other than 0x55 or 0xAA produces no request and leaves both arms intact.
- R6: A command written while flashBusy is high is dropped: no request is issued, but the arm it would have used is still consumed.
- R7: Control bit 0 is the program-write enable. A control write updates it only while intrEnable is low; while intrEnable is high, the bit keeps its value.
- R8: While the program-write enable is 1, xdataWrEn appears on flashWrStrobe in the same cycle. While it is 0, xdataWrEn appears on xramWrStrobe. The two strobes are never both high.
- R9: The program-write enable reads 0 in the cycle after any flash byte write.
- R10: Control bit 6 is the security bit. Writing 1 to it sets it; writing 0 is ignored. secureOut follows the bit.
- R11: The command register reads 0x00. The page register reads back the value written. The control register reads bits 0, 1 and 6 with all other bits 0. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWrEn | input | 1 | Register write strobe |
| sfrAddr | input | 8 | Register address |
| sfrWrData | input | 8 | Register write data |
| sfrRdData | output | 8 | Register read data, combinational from sfrAddr |
| intrEnable | input | 1 | Global interrupt enable of the core |
| debugEnable | input | 1 | Debug port active |
| flashBusy | input | 1 | Flash array busy with an erase or program |
| xdataWrEn | input | 1 | External-data write from the core |
| flashWrStrobe | output | 1 | External-data write routed to flash program space |
| xramWrStrobe | output | 1 | External-data write routed to external RAM |
| pageEraseReq | output | 1 | One-cycle page erase request |
| massEraseReq | output | 1 | One-cycle whole-array erase request |
| erasePage | output | 7 | Page number accompanying pageEraseReq |
| progWrEnable | output | 1 | Current program-write enable |
| secureOut | output | 1 | Security bit |

## Verification
The page erase is swept across all 128 pages. This shows that the page field is taken from bits 7:1 and is not off by one bit. The command register is swept across all 256 values with both arms set. This separates the two key values from every other value, and shows that a non-key value leaves the arms in place. The erase gates are then tried one at a time: missing arm, missing enable, debug port low, and flash busy. Each of these shows that its own precondition blocks the request and whether the arm is consumed. The control register is driven with interrupts enabled and disabled, with writes of 1 and of 0. This separates the gated, self-clearing program-write enable from the set-only security bit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  parameter int SFR_DW = 8;
  parameter int SFR_AW = 8;

  // strobes from the control half to the register half
  typedef struct packed {
    logic              ldPage;
    logic [SFR_DW-1:0] pageData;
    logic              ldPwe;
    logic              ctlPwe;
    logic              ldCtl;
    logic              ctlMeen;
    logic              ctlSecure;
    logic              clrMeen;
    logic              pageGo;
    logic              massGo;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter logic [SFR_AW-1:0] CMD_ADDR  = 8'h94,
  parameter logic [SFR_AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [SFR_AW-1:0] CTL_ADDR  = 8'hB2,
  parameter logic [SFR_DW-1:0] KEY_PAGE  = 8'h55,
  parameter logic [SFR_DW-1:0] KEY_MASS  = 8'hAA,
  parameter int PWE_BIT  = 0,
  parameter int MEEN_BIT = 1,
  parameter int SEC_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [SFR_DW-1:0] sfrWrData,
  input  logic              intrEnable,
  input  logic              debugEnable,
  input  logic              flashBusy,
  input  logic              meenCur,
  output ctlStrobe_t        strobe
);
  logic wrCmd, wrPage, wrCtl;
  logic keyPage, keyMass;
  logic pageArm;

  assign wrCmd   = sfrWrEn && (sfrAddr == CMD_ADDR);
  assign wrPage  = sfrWrEn && (sfrAddr == PAGE_ADDR);
  assign wrCtl   = sfrWrEn && (sfrAddr == CTL_ADDR);
  assign keyPage = wrCmd && (sfrWrData == KEY_PAGE);
  assign keyMass = wrCmd && (sfrWrData == KEY_MASS);

  // page arm: set by a page-register write, consumed by every page key
  always_ff @(posedge clk) begin
    if (!rstN)        pageArm <= 1'b0;
    else if (wrPage)  pageArm <= 1'b1;
    else if (keyPage) pageArm <= 1'b0;
  end

  always_comb begin
    strobe           = '0;
    strobe.ldPage    = wrPage;
    strobe.pageData  = sfrWrData;
    strobe.ldPwe     = wrCtl && !intrEnable;
    strobe.ctlPwe    = sfrWrData[PWE_BIT];
    strobe.ldCtl     = wrCtl;
    strobe.ctlMeen   = sfrWrData[MEEN_BIT];
    strobe.ctlSecure = sfrWrData[SEC_BIT];
    strobe.clrMeen   = keyMass;
    strobe.pageGo    = keyPage && pageArm && !flashBusy;
    strobe.massGo    = keyMass && meenCur && debugEnable && !flashBusy;
  end
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter logic [SFR_AW-1:0] CMD_ADDR  = 8'h94,
  parameter logic [SFR_AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [SFR_AW-1:0] CTL_ADDR  = 8'hB2,
  parameter int PWE_BIT  = 0,
  parameter int MEEN_BIT = 1,
  parameter int SEC_BIT  = 6,
  localparam int PAGE_W  = SFR_DW - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic              xdataWrEn,
  output logic [SFR_DW-1:0] sfrRdData,
  output logic              flashWrStrobe,
  output logic              xramWrStrobe,
  output logic              pageEraseReq,
  output logic              massEraseReq,
  output logic [PAGE_W-1:0] erasePage,
  output logic              pweCur,
  output logic              meenCur,
  output logic              secureCur
);
  logic [SFR_DW-1:0] pageReg;
  logic [SFR_DW-1:0] ctlView;

  assign flashWrStrobe = xdataWrEn && pweCur;
  assign xramWrStrobe  = xdataWrEn && !pweCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg      <= '0;
      pweCur       <= 1'b0;
      meenCur      <= 1'b0;
      secureCur    <= 1'b0;
      pageEraseReq <= 1'b0;
      massEraseReq <= 1'b0;
      erasePage    <= '0;
    end else begin
      if (strobe.ldPage) pageReg <= strobe.pageData;
      // a flash byte write clears the enable ahead of any control write
      if (flashWrStrobe)     pweCur <= 1'b0;
      else if (strobe.ldPwe) pweCur <= strobe.ctlPwe;
      if (strobe.clrMeen)    meenCur <= 1'b0;
      else if (strobe.ldCtl) meenCur <= strobe.ctlMeen;
      if (strobe.ldCtl && strobe.ctlSecure) secureCur <= 1'b1;
      pageEraseReq <= strobe.pageGo;
      massEraseReq <= strobe.massGo;
      if (strobe.pageGo) erasePage <= pageReg[SFR_DW-1:1];
    end
  end

  always_comb begin
    ctlView           = '0;
    ctlView[PWE_BIT]  = pweCur;
    ctlView[MEEN_BIT] = meenCur;
    ctlView[SEC_BIT]  = secureCur;
  end

  always_comb begin
    unique case (sfrAddr)
      PAGE_ADDR: sfrRdData = pageReg;
      CTL_ADDR:  sfrRdData = ctlView;
      CMD_ADDR:  sfrRdData = '0;
      default:   sfrRdData = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter logic [SFR_AW-1:0] CMD_ADDR  = 8'h94,
  parameter logic [SFR_AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [SFR_AW-1:0] CTL_ADDR  = 8'hB2,
  parameter logic [SFR_DW-1:0] KEY_PAGE  = 8'h55,
  parameter logic [SFR_DW-1:0] KEY_MASS  = 8'hAA,
  localparam int PAGE_W = SFR_DW - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [SFR_DW-1:0] sfrWrData,
  output logic [SFR_DW-1:0] sfrRdData,
  input  logic              intrEnable,
  input  logic              debugEnable,
  input  logic              flashBusy,
  input  logic              xdataWrEn,
  output logic              flashWrStrobe,
  output logic              xramWrStrobe,
  output logic              pageEraseReq,
  output logic              massEraseReq,
  output logic [PAGE_W-1:0] erasePage,
  output logic              progWrEnable,
  output logic              secureOut
);
  ctlStrobe_t strobe;
  logic meenCur;

  flash_cmd_ctrl #(
    .CMD_ADDR(CMD_ADDR), .PAGE_ADDR(PAGE_ADDR), .CTL_ADDR(CTL_ADDR),
    .KEY_PAGE(KEY_PAGE), .KEY_MASS(KEY_MASS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .intrEnable(intrEnable), .debugEnable(debugEnable),
    .flashBusy(flashBusy), .meenCur(meenCur), .strobe(strobe)
  );

  flash_cmd_dp #(
    .CMD_ADDR(CMD_ADDR), .PAGE_ADDR(PAGE_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sfrAddr(sfrAddr),
    .xdataWrEn(xdataWrEn), .sfrRdData(sfrRdData),
    .flashWrStrobe(flashWrStrobe), .xramWrStrobe(xramWrStrobe),
    .pageEraseReq(pageEraseReq), .massEraseReq(massEraseReq),
    .erasePage(erasePage), .pweCur(progWrEnable), .meenCur(meenCur),
    .secureCur(secureOut)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic clk,
  input logic rstN,
  input logic pageEraseReq,
  input logic massEraseReq,
  input logic flashBusy,
  input logic debugEnable,
  input logic flashWrStrobe,
  input logic xramWrStrobe,
  input logic progWrEnable,
  input logic secureOut
);
  AST_PAGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pageEraseReq |=> !pageEraseReq); // R2
  AST_MASS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    massEraseReq |=> !massEraseReq); // R4
  AST_MASS_DEBUG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(massEraseReq) |-> $past(debugEnable)); // R4
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageEraseReq) || $rose(massEraseReq) |-> !$past(flashBusy)); // R6
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flashWrStrobe && xramWrStrobe)); // R8
  AST_ROUTE_PWE: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |-> progWrEnable); // R8
  AST_PWE_SELFCLR: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |=> !progWrEnable); // R9
  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    secureOut |=> secureOut); // R10
endmodule

bind flash_cmd_regs flash_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .pageEraseReq(pageEraseReq),
  .massEraseReq(massEraseReq), .flashBusy(flashBusy),
  .debugEnable(debugEnable), .flashWrStrobe(flashWrStrobe),
  .xramWrStrobe(xramWrStrobe), .progWrEnable(progWrEnable),
  .secureOut(secureOut)
);

// File: tb/flash_cmd_regs_tb.sv
`timescale 1ns/1ps
module flash_cmd_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sfrWrEn = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWrData = 8'h00;
  logic [7:0] sfrRdData;
  logic intrEnable = 1'b0, debugEnable = 1'b1, flashBusy = 1'b0, xdataWrEn = 1'b0;
  logic flashWrStrobe, xramWrStrobe, pageEraseReq, massEraseReq;
  logic [6:0] erasePage;
  logic progWrEnable, secureOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CMD = 8'h94, A_PG = 8'hB7, A_CTL = 8'hB2;

  always #2 clk = ~clk;

  flash_cmd_regs u_dut (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .intrEnable(intrEnable),
    .debugEnable(debugEnable), .flashBusy(flashBusy), .xdataWrEn(xdataWrEn),
    .flashWrStrobe(flashWrStrobe), .xramWrStrobe(xramWrStrobe),
    .pageEraseReq(pageEraseReq), .massEraseReq(massEraseReq),
    .erasePage(erasePage), .progWrEnable(progWrEnable), .secureOut(secureOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // returns at the negedge after the capturing edge: requests are visible
  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrWrEn = 1'b1; sfrAddr = a; sfrWrData = d;
    @(negedge clk);
    sfrWrEn = 1'b0; sfrAddr = 8'h00;
  endtask

  task automatic sfrRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfrAddr = a;
    #1 d = sfrRdData;
  endtask

  task automatic reqs(input string req, input int expPage, input int expMass);
    check(req, int'(pageEraseReq), expPage);
    check(req, int'(massEraseReq), expMass);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    sfrRead(A_CMD, rd); check("R1 cmd", rd, 0);
    sfrRead(A_PG, rd);  check("R1 page", rd, 0);
    sfrRead(A_CTL, rd); check("R1 ctl", rd, 0);
    reqs("R1 req", 0, 0);
    check("R1 pwe", progWrEnable, 0);
    check("R1 sec", secureOut, 0);

    // R2 sweep all pages
    for (int p = 0; p < 128; p++) begin
      sfrWrite(A_PG, 8'(p << 1));
      sfrRead(A_PG, rd); check("R11 page readback", rd, (p << 1) & 8'hFF);
      sfrWrite(A_CMD, 8'h55);
      reqs("R2 issue", 1, 0);
      check("R2 page", erasePage, p);
      @(negedge clk);
      reqs("R2 one cycle", 0, 0);
    end
    // R3 no fresh arm
    sfrWrite(A_CMD, 8'h55); reqs("R3 unarmed", 0, 0);
    sfrWrite(A_PG, 8'h0A);  sfrWrite(A_CMD, 8'h55); reqs("R3 rearmed", 1, 0);
    check("R3 page", erasePage, 5);

    // R5 sweep every non-key command with both arms set
    sfrWrite(A_PG, 8'h20);
    sfrWrite(A_CTL, 8'h02);
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h55 && v != 8'hAA) begin
        sfrWrite(A_CMD, 8'(v));
        reqs("R5 non-key", 0, 0);
      end
    end
    sfrWrite(A_CMD, 8'h55); reqs("R5 page arm kept", 1, 0);
    check("R5 page", erasePage, 16);
    sfrWrite(A_CMD, 8'hAA); reqs("R4 mass issue", 0, 1);
    @(negedge clk); reqs("R4 one cycle", 0, 0);
    sfrRead(A_CTL, rd); check("R4 enable consumed", rd, 0);
    sfrWrite(A_CMD, 8'hAA); reqs("R4 no enable", 0, 0);
    // R4 debug port low
    sfrWrite(A_CTL, 8'h02);
    debugEnable = 1'b0;
    sfrWrite(A_CMD, 8'hAA); reqs("R4 debug low", 0, 0);
    sfrRead(A_CTL, rd); check("R4 cleared by key", rd, 0);
    debugEnable = 1'b1;
    sfrWrite(A_CTL, 8'h02); sfrWrite(A_CTL, 8'h00);
    sfrWrite(A_CMD, 8'hAA); reqs("R4 enable written 0", 0, 0);

    // R6 busy drops and consumes
    sfrWrite(A_PG, 8'h02); sfrWrite(A_CTL, 8'h02);
    flashBusy = 1'b1;
    sfrWrite(A_CMD, 8'h55); reqs("R6 page busy", 0, 0);
    sfrWrite(A_CMD, 8'hAA); reqs("R6 mass busy", 0, 0);
    flashBusy = 1'b0;
    sfrWrite(A_CMD, 8'h55); reqs("R6 page consumed", 0, 0);
    sfrWrite(A_CMD, 8'hAA); reqs("R6 mass consumed", 0, 0);

    // R7 interrupt gating
    intrEnable = 1'b1;
    sfrWrite(A_CTL, 8'h01); sfrRead(A_CTL, rd); check("R7 blocked set", rd, 0);
    intrEnable = 1'b0;
    sfrWrite(A_CTL, 8'h01); sfrRead(A_CTL, rd); check("R7 set", rd, 1);
    intrEnable = 1'b1;
    sfrWrite(A_CTL, 8'h00); sfrRead(A_CTL, rd); check("R7 blocked clear", rd, 1);
    intrEnable = 1'b0;

    // R8/R9 routing and self clear
    @(negedge clk); xdataWrEn = 1'b1;
    #1 check("R8 to flash", flashWrStrobe, 1); check("R8 not ram", xramWrStrobe, 0);
    @(negedge clk); xdataWrEn = 1'b0;
    check("R9 self clear", progWrEnable, 0);
    sfrRead(A_CTL, rd); check("R9 read", rd, 0);
    @(negedge clk); xdataWrEn = 1'b1;
    #1 check("R8 to ram", xramWrStrobe, 1); check("R8 not flash", flashWrStrobe, 0);
    @(negedge clk); xdataWrEn = 1'b0;

    // R10 security
    sfrWrite(A_CTL, 8'h40); check("R10 set", secureOut, 1);
    sfrWrite(A_CTL, 8'h00); check("R10 sticky", secureOut, 1);
    sfrRead(A_CTL, rd); check("R10 read", rd, 8'h40);

    // R11 read masks
    sfrWrite(A_CTL, 8'hFF); sfrRead(A_CTL, rd); check("R11 ctl mask", rd, 8'h43);
    sfrRead(A_CMD, rd); check("R11 cmd", rd, 0);
    sfrRead(8'h3C, rd); check("R11 unmapped", rd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule